// File: doc/BRIEF.md
# Configuration Bitstream Descrambler with Pin-Pattern Serializer

This block sits between a buffer of scrambled configuration bytes and a pin driver that programs an FPGA over a two-wire serial link (one data wire, one clock wire). Each incoming byte is XORed with a keystream byte. The keystream comes from a 32-bit state that a fixed modular recurrence advances once per byte. Each descrambled bit is then expanded, most significant bit first, into a pair of pin-pattern bytes. The first byte of the pair raises the clock wire and the second lowers it, and the data wire holds the bit across both. One input byte therefore yields sixteen output bytes.

The input is a valid/ready byte stream with a last flag. The output is a valid/ready stream of pin patterns. A start pulse reloads the keystream seed and abandons any byte that is still being serialized. A sticky done flag rises once every pattern of the byte marked last has been taken. The remainder modulo 177 is found by a shift-and-subtract reducer that handles one bit per cycle, so the next keystream byte is computed in the background while the current byte is shifted out. A parameter can select a single-cycle divider instead.

Top module: `cfg_descramble_serializer`

## Requirements
- R1: After reset or a start pulse the keystream state is 0x3F6DF2AB, and the first byte accepted is descrambled with the low 8 bits of that state after one update.
- R2: Each accepted byte first advances the state to ((state + 0x0A853753) mod 177) + state * 0x08034052. Every sum and product wraps at 32 bits. Later bytes of a stream keep using the advancing state.
- R3: The descrambled byte is the input byte XOR the low 8 bits of the updated state, so an input of 0x00 yields the keystream byte and an input of 0xFF yields its complement.
- R4: Each descrambled bit is sent most significant bit first as two output bytes. The first has bit 6 equal to the data bit and bit 0 = 1. The second has the same bit 6 and bit 0 = 0. Exactly 16 output bytes are produced per input byte, after which out_valid falls if no new byte has been accepted.
- R5: Output bits 7 and 5 down to 1 are always 0 while out_valid is high.
- R6: in_ready is low during reset recovery, in the cycle after a byte is accepted, and for as long as the serializer holds a byte or the keystream byte is not ready. No byte is taken while in_ready is low.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R8: done rises in the cycle after the 16th output byte of a byte flagged last is accepted. It is low before that, and it stays high until a start pulse.
- R9: A start pulse takes priority over all other inputs. In the next cycle out_valid and done are low, any partially sent byte is dropped, and the next byte accepted is descrambled as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Reseed pulse; aborts the current byte and clears done |
| in_valid_i | input | 1 | Scrambled byte present |
| in_data_i | input | 8 | Scrambled byte |
| in_last_i | input | 1 | Byte is the final one of the stream |
| in_ready_o | output | 1 | Block takes the byte at this edge |
| out_valid_o | output | 1 | Pin pattern present |
| out_data_o | output | 8 | Pin pattern: bit 6 data wire, bit 0 clock wire |
| out_ready_i | input | 1 | Pin driver takes the pattern |
| done_o | output | 1 | Sticky: last byte fully serialized |

## Verification
The bench compares every output against its own model of the recurrence over a stream long enough to take the state through many different mod-177 remainders. An error in the wrap width or the reduction would corrupt later bytes while leaving the first one correct. All-zero and all-ones input bytes expose a swapped XOR operand or a bit-order error. Output stalls at uneven intervals catch a serializer that advances, or changes its pattern, while the driver is not ready. The done flag is sampled on the 16th acceptance and on the cycle after it, which exposes a flag raised one pattern early. A start pulse in the middle of a byte must flush the output and restart the keystream, so a design that kept the old state would produce a wrong first byte after the abort.

// File: rtl/cfgds_pkg.sv
package cfgds_pkg;
   typedef enum logic {
      PH_CLK_HIGH = 1'b0,
      PH_CLK_LOW  = 1'b1
   } ser_phase_e;

   function automatic logic clk_level(ser_phase_e ph);
      return (ph == PH_CLK_HIGH);
   endfunction
endpackage

// File: rtl/cfgds_keygen.sv
module cfgds_keygen #(
   parameter int unsigned STATE_W = 32,
   parameter int unsigned KEY_W = 8,
   parameter logic [STATE_W-1:0] SEED = 32'h3F6DF2AB,
   parameter logic [STATE_W-1:0] ADD_K = 32'h0A853753,
   parameter logic [STATE_W-1:0] MUL_K = 32'h08034052,
   parameter int unsigned MOD_K = 177,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reseed_i,
   input  logic advance_i,
   output logic key_valid_o,
   output logic [KEY_W-1:0] key_o
);
   localparam int unsigned REM_W = $clog2(MOD_K) + 1;
   localparam int unsigned CNT_W = $clog2(STATE_W + 1);

   if (MOD_K < 2) begin : g_bad_mod
      $error("cfgds_keygen: MOD_K must be at least 2");
   end
   if (KEY_W > STATE_W) begin : g_bad_key
      $error("cfgds_keygen: KEY_W exceeds STATE_W");
   end

   logic [STATE_W-1:0] state_q;
   logic valid_q;

   assign key_valid_o = valid_q;
   assign key_o = state_q[KEY_W-1:0];

   if (ITERATIVE) begin : g_iter
      logic [STATE_W-1:0] dividend_q;
      logic [REM_W-1:0] rem_q, trial, rem_nxt;
      logic [CNT_W-1:0] cnt_q;
      logic busy_q;

      always_comb begin
         trial = {rem_q[REM_W-2:0], dividend_q[STATE_W-1]};
         rem_nxt = (trial >= REM_W'(MOD_K)) ? trial - REM_W'(MOD_K) : trial;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state_q <= SEED;
            dividend_q <= SEED + ADD_K;
            rem_q <= '0;
            cnt_q <= CNT_W'(STATE_W);
            busy_q <= 1'b1;
            valid_q <= 1'b0;
         end else if (reseed_i) begin
            state_q <= SEED;
            dividend_q <= SEED + ADD_K;
            rem_q <= '0;
            cnt_q <= CNT_W'(STATE_W);
            busy_q <= 1'b1;
            valid_q <= 1'b0;
         end else if (advance_i) begin
            dividend_q <= state_q + ADD_K;
            rem_q <= '0;
            cnt_q <= CNT_W'(STATE_W);
            busy_q <= 1'b1;
            valid_q <= 1'b0;
         end else if (busy_q) begin
            dividend_q <= {dividend_q[STATE_W-2:0], 1'b0};
            rem_q <= rem_nxt;
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               valid_q <= 1'b1;
               state_q <= STATE_W'(rem_nxt) + state_q * MUL_K;
            end
         end
      end
   end else begin : g_direct
      logic pend_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state_q <= SEED;
            pend_q <= 1'b1;
            valid_q <= 1'b0;
         end else if (reseed_i) begin
            state_q <= SEED;
            pend_q <= 1'b1;
            valid_q <= 1'b0;
         end else if (advance_i) begin
            pend_q <= 1'b1;
            valid_q <= 1'b0;
         end else if (pend_q) begin
            state_q <= ((state_q + ADD_K) % STATE_W'(MOD_K)) + state_q * MUL_K;
            pend_q <= 1'b0;
            valid_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfgds_bitbang.sv
module cfgds_bitbang #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned OUT_W = 8,
   parameter int unsigned DATA_POS = 6,
   parameter int unsigned CLK_POS = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_i,
   input  logic load_i,
   input  logic [BYTE_W-1:0] load_data_i,
   input  logic load_last_i,
   output logic busy_o,
   output logic out_valid_o,
   output logic [OUT_W-1:0] out_data_o,
   input  logic out_ready_i,
   output logic last_done_o
);
   import cfgds_pkg::*;

   localparam int unsigned IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

   if (DATA_POS == CLK_POS || DATA_POS >= OUT_W || CLK_POS >= OUT_W) begin : g_bad_pos
      $error("cfgds_bitbang: pin positions invalid");
   end

   logic [BYTE_W-1:0] shreg_q;
   logic [IDX_W-1:0] idx_q;
   ser_phase_e phase_q;
   logic active_q, last_q;
   logic take, final_pair;

   assign take = active_q && out_ready_i;
   assign final_pair = (idx_q == IDX_W'(BYTE_W - 1)) && (phase_q == PH_CLK_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         idx_q <= '0;
         phase_q <= PH_CLK_HIGH;
         active_q <= 1'b0;
         last_q <= 1'b0;
      end else if (flush_i) begin
         active_q <= 1'b0;
         phase_q <= PH_CLK_HIGH;
         idx_q <= '0;
         last_q <= 1'b0;
      end else if (load_i) begin
         shreg_q <= load_data_i;
         idx_q <= '0;
         phase_q <= PH_CLK_HIGH;
         active_q <= 1'b1;
         last_q <= load_last_i;
      end else if (take) begin
         if (phase_q == PH_CLK_HIGH) begin
            phase_q <= PH_CLK_LOW;
         end else begin
            phase_q <= PH_CLK_HIGH;
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
            idx_q <= idx_q + IDX_W'(1);
            if (final_pair) active_q <= 1'b0;
         end
      end
   end

   assign last_done_o = take && final_pair && last_q && !flush_i;
   assign busy_o = active_q;
   assign out_valid_o = active_q;

   for (genvar b = 0; b < OUT_W; b++) begin : g_pin
      if (b == DATA_POS) begin : g_data
         assign out_data_o[b] = active_q && shreg_q[BYTE_W-1];
      end else if (b == CLK_POS) begin : g_clk
         assign out_data_o[b] = active_q && clk_level(phase_q);
      end else begin : g_zero
         assign out_data_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/cfg_descramble_serializer.sv
module cfg_descramble_serializer #(
   parameter int unsigned STATE_W = 32,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned OUT_W = 8,
   parameter logic [STATE_W-1:0] SEED = 32'h3F6DF2AB,
   parameter logic [STATE_W-1:0] ADD_K = 32'h0A853753,
   parameter logic [STATE_W-1:0] MUL_K = 32'h08034052,
   parameter int unsigned MOD_K = 177,
   parameter int unsigned DATA_POS = 6,
   parameter int unsigned CLK_POS = 0,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic in_valid_i,
   input  logic [BYTE_W-1:0] in_data_i,
   input  logic in_last_i,
   output logic in_ready_o,
   output logic out_valid_o,
   output logic [OUT_W-1:0] out_data_o,
   input  logic out_ready_i,
   output logic done_o
);
   logic key_valid, ser_busy, accept, last_done, done_q;
   logic [BYTE_W-1:0] key;

   assign in_ready_o = key_valid && !ser_busy;
   assign accept = in_valid_i && in_ready_o && !start_i;

   cfgds_keygen #(
      .STATE_W(STATE_W), .KEY_W(BYTE_W), .SEED(SEED), .ADD_K(ADD_K),
      .MUL_K(MUL_K), .MOD_K(MOD_K), .ITERATIVE(ITERATIVE)
   ) u_keygen (
      .clk(clk), .rst_n(rst_n), .reseed_i(start_i), .advance_i(accept),
      .key_valid_o(key_valid), .key_o(key)
   );

   cfgds_bitbang #(
      .BYTE_W(BYTE_W), .OUT_W(OUT_W), .DATA_POS(DATA_POS), .CLK_POS(CLK_POS)
   ) u_bitbang (
      .clk(clk), .rst_n(rst_n), .flush_i(start_i), .load_i(accept),
      .load_data_i(in_data_i ^ key), .load_last_i(in_last_i),
      .busy_o(ser_busy), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
      .out_ready_i(out_ready_i), .last_done_o(last_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else if (start_i) done_q <= 1'b0;
      else if (last_done) done_q <= 1'b1;
   end

   assign done_o = done_q;
endmodule

// File: rtl/cfgds_checker.sv
module cfgds_checker #(
   parameter int unsigned OUT_W = 8,
   parameter int unsigned DATA_POS = 6,
   parameter int unsigned CLK_POS = 0
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic in_valid_i,
   input logic in_ready_o,
   input logic out_valid_o,
   input logic [OUT_W-1:0] out_data_o,
   input logic out_ready_i,
   input logic done_o
);
   localparam logic [OUT_W-1:0] PIN_MASK = (OUT_W'(1) << DATA_POS) | (OUT_W'(1) << CLK_POS);

   // R5
   p_unused_pins_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> ((out_data_o & ~PIN_MASK) == '0));

   // R6
   p_no_take_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_o |-> !out_valid_o);

   // R6
   p_ready_drops_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid_i && in_ready_o && !start_i) |=> !in_ready_o);

   // R7
   p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i && !start_i) |=> (out_valid_o && $stable(out_data_o)));

   // R4
   p_clock_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i && out_data_o[CLK_POS] && !start_i) |=>
      (out_valid_o && !out_data_o[CLK_POS] && (out_data_o[DATA_POS] == $past(out_data_o[DATA_POS]))));

   // R9
   p_start_flushes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!out_valid_o && !done_o));

   // R8
   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);
endmodule

bind cfg_descramble_serializer cfgds_checker #(
   .OUT_W(OUT_W), .DATA_POS(DATA_POS), .CLK_POS(CLK_POS)
) u_cfgds_checker (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
   .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
   .out_ready_i(out_ready_i), .done_o(done_o)
);

// File: tb/cfg_descramble_serializer_test.sv
`timescale 1ns/1ps
module cfg_descramble_serializer_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic in_valid_i = 1'b0;
   logic [7:0] in_data_i = '0;
   logic in_last_i = 1'b0;
   logic in_ready_o;
   logic out_valid_o;
   logic [7:0] out_data_o;
   logic out_ready_i = 1'b0;
   logic done_o;

   int checks = 0;
   int failures = 0;
   logic [31:0] ks;
   bit done_exp = 1'b0;

   always #2.5 clk = ~clk;

   cfg_descramble_serializer uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
      .in_data_i(in_data_i), .in_last_i(in_last_i), .in_ready_o(in_ready_o),
      .out_valid_o(out_valid_o), .out_data_o(out_data_o),
      .out_ready_i(out_ready_i), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] model_next();
      logic [31:0] t;
      t = ks + 32'h0A853753;
      ks = (t % 32'd177) + ks * 32'h08034052;
      return ks[7:0];
   endfunction

   task automatic push_byte(input logic [7:0] b, input bit last);
      @(negedge clk);
      in_valid_i = 1'b1;
      in_data_i = b;
      in_last_i = last;
      while (!in_ready_o) @(negedge clk);
      @(negedge clk);
      in_valid_i = 1'b0;
      in_last_i = 1'b0;
      chk(in_ready_o == 1'b0, "R6 ready low after take", 32'(in_ready_o), 0);
   endtask

   task automatic xfer_byte(input logic [7:0] b, input bit last, input int mode, input string tag);
      logic [7:0] exp, rebuilt;
      logic [7:0] prev_data, e;
      bit prev_stall;
      int i, k;
      exp = b ^ model_next();
      push_byte(b, last);
      i = 0; k = 0; prev_stall = 0; rebuilt = '0; prev_data = '0;
      while (i < 16) begin
         case (mode)
            1: out_ready_i = (k % 3) != 0;
            2: out_ready_i = (k % 2) == 1;
            default: out_ready_i = 1'b1;
         endcase
         k++;
         if (prev_stall)
            chk(out_valid_o && out_data_o == prev_data, "R7 hold on stall", 32'(out_data_o), 32'(prev_data));
         if (out_valid_o && out_ready_i) begin
            e = {1'b0, exp[7 - i/2], 5'b0, ((i % 2) == 0)};
            chk(out_data_o == e, "R4 pin pattern", 32'(out_data_o), 32'(e));
            chk((out_data_o & 8'hBE) == 8'h00, "R5 idle pins zero", 32'(out_data_o), 0);
            if ((i % 2) == 0) rebuilt = {rebuilt[6:0], out_data_o[6]};
            if (i == 15)
               chk(done_o == done_exp, "R8 done not early", 32'(done_o), 32'(done_exp));
            i++;
         end
         prev_stall = out_valid_o && !out_ready_i;
         prev_data = out_data_o;
         @(negedge clk);
      end
      out_ready_i = 1'b0;
      if (last) done_exp = 1'b1;
      chk(out_valid_o == 1'b0, "R4 sixteen outputs only", 32'(out_valid_o), 0);
      chk(done_o == done_exp, "R8 done after last", 32'(done_o), 32'(done_exp));
      chk(rebuilt == exp, tag, 32'(rebuilt), 32'(exp));
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      ks = 32'h3F6DF2AB;
      done_exp = 1'b0;
      chk(out_valid_o == 1'b0, "R9 start flushes output", 32'(out_valid_o), 0);
      chk(done_o == 1'b0, "R9 start clears done", 32'(done_o), 0);
   endtask

   task automatic t_reset();
      ks = 32'h3F6DF2AB;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid_o == 1'b0, "R1 reset out_valid", 32'(out_valid_o), 0);
      chk(done_o == 1'b0, "R8 reset done", 32'(done_o), 0);
      chk(in_ready_o == 1'b0, "R6 ready low in key setup", 32'(in_ready_o), 0);
   endtask

   task automatic t_stream_a();
      xfer_byte(8'h00, 1'b0, 0, "R1 first byte keystream");
      xfer_byte(8'hFF, 1'b0, 1, "R3 complement of keystream");
      xfer_byte(8'h3C, 1'b0, 0, "R2 third byte");
      xfer_byte(8'hA5, 1'b1, 2, "R2 last byte");
      repeat (5) @(negedge clk);
      chk(done_o == 1'b1, "R8 done sticky", 32'(done_o), 1);
   endtask

   task automatic t_stream_b();
      pulse_start();
      xfer_byte(8'h00, 1'b0, 2, "R3 keystream after reseed");
      xfer_byte(8'h34, 1'b1, 1, "R2 second after reseed");
   endtask

   task automatic t_abort();
      pulse_start();
      void'(model_next());
      push_byte(8'h77, 1'b1);
      out_ready_i = 1'b1;
      repeat (3) @(negedge clk);
      out_ready_i = 1'b0;
      pulse_start();
      repeat (4) @(negedge clk);
      chk(out_valid_o == 1'b0, "R9 aborted byte dropped", 32'(out_valid_o), 0);
      chk(done_o == 1'b0, "R9 abort leaves done low", 32'(done_o), 0);
      xfer_byte(8'h5A, 1'b0, 0, "R9 fresh keystream after abort");
   endtask

   task automatic t_long();
      pulse_start();
      for (int n = 0; n < 20; n++)
         xfer_byte(8'(n * 37 + 11), n == 19, n % 3, "R2 long stream");
   endtask

   initial begin
      t_reset();
      t_stream_a();
      t_stream_b();
      t_abort();
      t_long();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule